// File: doc/BRIEF.md
# Sliding-Window Switch-State Sample Classifier

This block takes a stream of voltage samples that arrive at no fixed phase relative to a switching cycle. It keeps the sixteen most recent samples in a window. From that window it reports the smallest value, the largest value and the truncated average. Each sample is also labelled as taken with the power switch open or with the switch closed. A closed switch lets load current drop voltage across the supply wiring, which pulls the reading down. An open switch gives the true open-circuit level.

The label comes from comparing the sample with the window average, once the sample itself is included in the window. A reading at or above the average is treated as switch-open. A reading below it is treated as switch-closed. The statistics and the label are marked invalid until the window has been filled once after reset. The label is registered and comes with its own one-cycle valid pulse. The surrounding logic can use these results to keep only the trustworthy readings.

Top module: `window_classifier`

## Requirements
- R1: While `rstN` is low and directly after reset, `statsValid` and `classValid` are 0.
- R2: `statsValid` becomes 1 in the cycle after the clock edge that accepts the 16th sample since reset, and then stays 1. It is 0 before that edge.
- R3: While `statsValid` is 1, `maxOut` equals the largest of the 16 most recently accepted samples.
- R4: While `statsValid` is 1, `minOut` equals the smallest of the 16 most recently accepted samples.
- R5: While `statsValid` is 1, `meanOut` equals the sum of the 16 most recently accepted samples divided by 16, rounded down.
- R6: `classValid` is a one-cycle pulse that follows each accepted sample (edge with `sampleValid`=1) by one cycle, counting the sample that completes the first window. It never pulses for the first 15 samples, and never pulses in a cycle after an edge without a sample.
- R7: When `classValid` is 1, `classOff` is 1 if the sample that caused the pulse is greater than or equal to `meanOut` of the window holding that sample. It is 0 (switch closed) if the sample is smaller.
- R8: The window drops its oldest entry when a new sample enters. An extreme value leaves `maxOut` or `minOut` exactly 16 samples after it entered.
- R9: A clock edge with `sampleValid` = 0 leaves `minOut`, `maxOut` and `meanOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| sampleIn | input | SAMPLE_W | Voltage sample value, unsigned |
| sampleValid | input | 1 | Accepts `sampleIn` at this edge |
| minOut | output | SAMPLE_W | Smallest sample in the window |
| maxOut | output | SAMPLE_W | Largest sample in the window |
| meanOut | output | SAMPLE_W | Window sum shifted right by 4 |
| statsValid | output | 1 | Window has been filled since reset |
| classOff | output | 1 | 1 = switch-open reading, 0 = switch-closed reading |
| classValid | output | 1 | One-cycle pulse qualifying `classOff` |

## Verification
A wrong running sum shows up in `meanOut` in the cycle after the faulty update. Because the sum is never rebuilt, that error stays until reset, so every later average check catches it. It also moves the switch-state labels of samples near the average. A wrong tap or eviction in the window leaves an old extreme in `maxOut` or `minOut` past its sixteenth replacement. The bench therefore checks the extremes directly after a spike and a dip have been pushed out. An off-by-one in the fill counter moves both the first `classValid` pulse and the rise of `statsValid` by one sample, and this is checked at the 15th and 16th samples.

// File: rtl/wc_pkg.sv
package wc_pkg;

  // Strobes passed from the control module to the datapath each cycle
  typedef struct packed {
    logic load;     // shift the new sample in and update the running sum
    logic publish;  // register a classification result for this sample
  } wcStrobe_t;

endpackage

// File: rtl/wc_ctrl.sv
module wc_ctrl
  import wc_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleValid,
  output wcStrobe_t strobe,
  output logic      statsValid
);

  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int CNT_W = DEPTH_LOG2 + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] fillCnt;
  logic             windowFull;
  logic             fillsNow;

  assign windowFull = (fillCnt == FULL_CNT);
  assign fillsNow   = windowFull || (fillCnt == LAST_CNT);

  // Fill counter saturates once the window has been loaded completely
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (sampleValid && !windowFull) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.load    = sampleValid;
    strobe.publish = sampleValid && fillsNow;
  end

  assign statsValid = windowFull;

endmodule

// File: rtl/wc_extremes.sv
module wc_extremes #(
  parameter int SAMPLE_W   = 10,
  parameter int DEPTH_LOG2 = 4
) (
  input  logic [(1<<DEPTH_LOG2)-1:0][SAMPLE_W-1:0] taps,
  output logic [SAMPLE_W-1:0]                      minVal,
  output logic [SAMPLE_W-1:0]                      maxVal
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  // Full rescan of every tap, so evicted extremes disappear at once
  always_comb begin
    minVal = taps[0];
    maxVal = taps[0];
    for (int i = 1; i < DEPTH; i++) begin
      if (taps[i] < minVal) minVal = taps[i];
      if (taps[i] > maxVal) maxVal = taps[i];
    end
  end

endmodule

// File: rtl/wc_datapath.sv
module wc_datapath
  import wc_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  wcStrobe_t                                strobe,
  input  logic [SAMPLE_W-1:0]                      sampleIn,
  output logic [(1<<DEPTH_LOG2)-1:0][SAMPLE_W-1:0] taps,
  output logic [SAMPLE_W-1:0]                      meanOut,
  output logic                                     classOff,
  output logic                                     classValid
);

  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int SUM_W = SAMPLE_W + DEPTH_LOG2;

  logic [SUM_W-1:0]    sumReg;
  logic [SUM_W-1:0]    sumNext;
  logic [SAMPLE_W-1:0] meanNext;
  logic [SAMPLE_W-1:0] evicted;

  assign evicted  = taps[DEPTH-1];
  // Entries start at zero, so the running sum is also correct while filling
  assign sumNext  = sumReg + SUM_W'(sampleIn) - SUM_W'(evicted);
  assign meanNext = sumNext[SUM_W-1:DEPTH_LOG2];
  assign meanOut  = sumReg[SUM_W-1:DEPTH_LOG2];

  // Tap 0 holds the newest sample, the last tap the oldest
  always_ff @(posedge clk) begin
    if (!rstN) begin
      taps   <= '0;
      sumReg <= '0;
    end else if (strobe.load) begin
      taps[0] <= sampleIn;
      for (int i = 1; i < DEPTH; i++) begin
        taps[i] <= taps[i-1];
      end
      sumReg <= sumNext;
    end
  end

  // Label against the average of the window that already holds this sample
  always_ff @(posedge clk) begin
    if (!rstN) begin
      classOff   <= 1'b0;
      classValid <= 1'b0;
    end else begin
      classValid <= strobe.publish;
      if (strobe.publish) begin
        classOff <= (sampleIn >= meanNext);
      end
    end
  end

endmodule

// File: rtl/window_classifier.sv
module window_classifier
  import wc_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  output logic [SAMPLE_W-1:0] minOut,
  output logic [SAMPLE_W-1:0] maxOut,
  output logic [SAMPLE_W-1:0] meanOut,
  output logic                statsValid,
  output logic                classOff,
  output logic                classValid
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  wcStrobe_t                          strobe;
  logic [DEPTH-1:0][SAMPLE_W-1:0]     taps;

  wc_ctrl #(.DEPTH_LOG2(DEPTH_LOG2)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .strobe     (strobe),
    .statsValid (statsValid)
  );

  wc_datapath #(.SAMPLE_W(SAMPLE_W), .DEPTH_LOG2(DEPTH_LOG2)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sampleIn  (sampleIn),
    .taps      (taps),
    .meanOut   (meanOut),
    .classOff  (classOff),
    .classValid(classValid)
  );

  wc_extremes #(.SAMPLE_W(SAMPLE_W), .DEPTH_LOG2(DEPTH_LOG2)) u_ext (
    .taps  (taps),
    .minVal(minOut),
    .maxVal(maxOut)
  );

endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int SAMPLE_W = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] minOut,
  input logic [SAMPLE_W-1:0] maxOut,
  input logic [SAMPLE_W-1:0] meanOut,
  input logic                statsValid,
  input logic                classValid
);

  AST_STATS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statsValid |=> statsValid); // R2

  AST_CLASS_AFTER_FULL: assert property (@(posedge clk) disable iff (!rstN)
    classValid |-> statsValid); // R6

  AST_NO_CLASS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !classValid); // R6

  AST_MIN_NOT_ABOVE_MAX: assert property (@(posedge clk) disable iff (!rstN)
    statsValid |-> (minOut <= maxOut)); // R3

  AST_MEAN_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    statsValid |-> (minOut <= meanOut && meanOut <= maxOut)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (statsValid && !sampleValid) |=> ($stable(minOut) && $stable(maxOut) && $stable(meanOut))); // R9

endmodule

bind window_classifier wc_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .minOut     (minOut),
  .maxOut     (maxOut),
  .meanOut    (meanOut),
  .statsValid (statsValid),
  .classValid (classValid)
);

// File: tb/window_classifier_test.sv
module window_classifier_test;

  localparam int W = 10;
  localparam int DEPTH = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] sampleIn = '0;
  logic         sampleValid = 1'b0;
  logic [W-1:0] minOut, maxOut, meanOut;
  logic         statsValid, classOff, classValid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    bit expClass;
    bit expOff;
    bit full;
    int mn;
    int mx;
    int mean;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t lastItem;
  bit       haveLast = 0;
  int       model[$];
  int       sampleCount = 0;

  always #5 clk = ~clk;

  window_classifier #(.SAMPLE_W(W), .DEPTH_LOG2(4)) uut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .minOut(minOut), .maxOut(maxOut), .meanOut(meanOut), .statsValid(statsValid),
    .classOff(classOff), .classValid(classValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: present one sample and queue what the ports must show afterwards
  task automatic send(input int v);
    expItem_t it;
    int sum;
    @(negedge clk);
    sampleIn = W'(v);
    sampleValid = 1'b1;
    model.push_front(v);
    if (model.size() > DEPTH) void'(model.pop_back());
    sampleCount++;
    it.full = (sampleCount >= DEPTH);
    it.expClass = it.full;
    it.mn = model[0];
    it.mx = model[0];
    sum = 0;
    foreach (model[i]) begin
      sum += model[i];
      if (model[i] < it.mn) it.mn = model[i];
      if (model[i] > it.mx) it.mx = model[i];
    end
    it.mean = sum / DEPTH;
    it.expOff = (v >= it.mean);
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sampleValid = 1'b0;
    end
  endtask

  // Monitor: compare each cycle's outputs just after the edge
  always @(posedge clk) begin
    #1;
    if (rstN && !finished) begin
      if (sampleValid) begin
        expItem_t it;
        if (expQ.size() == 0) begin
          check(0, "R6", "scoreboard empty at strobe", 0, 1);
        end else begin
          it = expQ.pop_front();
          check(classValid == it.expClass, "R6", "classValid after sample", classValid, it.expClass);
          check(statsValid == it.full, "R2", "statsValid after sample", statsValid, it.full);
          if (it.expClass)
            check(classOff == it.expOff, "R7", "classOff label", classOff, it.expOff);
          if (it.full) begin
            check(int'(maxOut) == it.mx, "R3", "maxOut", maxOut, it.mx);
            check(int'(minOut) == it.mn, "R4", "minOut", minOut, it.mn);
            check(int'(meanOut) == it.mean, "R5", "meanOut", meanOut, it.mean);
          end
          lastItem = it;
          haveLast = 1;
        end
      end else if (haveLast) begin
        check(classValid == 1'b0, "R6", "classValid without sample", classValid, 0);
        if (lastItem.full) begin
          check(int'(maxOut) == lastItem.mx, "R9", "maxOut held while idle", maxOut, lastItem.mx);
          check(int'(minOut) == lastItem.mn, "R9", "minOut held while idle", minOut, lastItem.mn);
          check(int'(meanOut) == lastItem.mean, "R9", "meanOut held while idle", meanOut, lastItem.mean);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(statsValid == 1'b0, "R1", "statsValid in reset", statsValid, 0);
    check(classValid == 1'b0, "R1", "classValid in reset", classValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(statsValid == 1'b0, "R1", "statsValid after reset", statsValid, 0);
    check(classValid == 1'b0, "R1", "classValid after reset", classValid, 0);

    // Fill: first 15 samples give no label and no valid statistics
    for (int i = 0; i < 15; i++) send(100 + 3 * i);
    idle(2);
    check(statsValid == 1'b0, "R2", "statsValid after 15 samples", statsValid, 0);
    send(160);
    idle(3);
    check(statsValid == 1'b1, "R2", "statsValid after 16 samples", statsValid, 1);

    // Constant window: sample equal to average counts as switch open
    for (int i = 0; i < 16; i++) begin
      send(500);
      if (i % 4 == 0) idle(1);
    end

    // Spike then eviction
    send(1023);
    for (int i = 0; i < 15; i++) send(500);
    idle(2);
    check(int'(maxOut) == 1023, "R8", "spike still inside window", maxOut, 1023);
    send(500);
    idle(2);
    check(int'(maxOut) == 500, "R8", "spike evicted from maxOut", maxOut, 500);

    // Dip then eviction
    send(0);
    for (int i = 0; i < 16; i++) send(500);
    idle(2);
    check(int'(minOut) == 500, "R8", "dip evicted from minOut", minOut, 500);

    // Switching pattern: open readings high, closed readings pulled down
    for (int i = 0; i < 40; i++) send((i % 2) ? 600 : 800);
    idle(2);
    for (int i = 0; i < 30; i++) send((i % 5 == 0) ? 800 : 620);

    // Irregular values and gaps
    for (int i = 0; i < 80; i++) begin
      send($urandom_range(0, 1023));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    send(1023);
    send(0);
    idle(4);

    finished = 1;
    check(expQ.size() == 0, "R6", "scoreboard drained", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule